// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Tracking

This block sits between a serial receiver's deserializer and the register interface a CPU reads. Every completed character arrives on a single-cycle write strobe, together with three error bits: parity, framing and break. The block keeps up to sixteen of these entries in arrival order. The CPU always sees the oldest entry. It takes that entry with a read strobe and clears status with a separate status-read strobe.

The queue raises two service requests:
- A data-available request tied to a programmable fill threshold.
- A character-timeout request for a few bytes left unread after the line has gone quiet.

It also reports the following status:
- The error bits of the entry at the head only.
- A flag marking a character lost to a full queue.
- A sticky flag that stays set while any errored entry is still queued.

A flush command empties the queue at once. The deserializer ahead of it is not touched.

Top module: `uart_rxq`

## Requirements
- R1: Up to 16 entries are held and read out in arrival order. `count_o` gives the number stored. `data_ready_o` is high exactly when `count_o` is non-zero.
- R2: `trig_sel_i` selects the fill threshold: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. `avail_req_o` is high once `count_o` is at or above that threshold.
- R3: `avail_req_o` falls in the same cycle that `count_o` drops below the threshold.
- R4: One character time is `frame_ticks_i` pulses of `tick_i`. `timeout_req_o` rises on the tick that completes four character times (4*`frame_ticks_i` ticks). It rises only while at least one entry is stored and with no write strobe and no pop during that period. Before the timeout fires, a write strobe or a pop restarts the count.
- R5: Once `timeout_req_o` is high, further write strobes leave it high. A single pop clears it and restarts the count. Emptying the queue also clears it.
- R6: A write strobe that arrives while 16 entries are stored is discarded. It raises `overrun_o` on the next cycle. `overrun_o` clears on a status read.
- R7: `head_pe_o`, `head_fe_o` and `head_bi_o` show the error bits of the entry currently at the head. They are zero when the queue is empty. After a status read they read zero until the head entry changes.
- R8: `err_sum_o` sets one cycle after any errored entry is stored. It stays set until a status read occurs at a time when no errored entry remains.
- R9: `flush_i` empties the queue in one cycle. A flush takes priority over a write or pop in the same cycle.
- R10: `rd_data_o` shows the head entry's data, or 8'h00 when the queue is empty. A pop on an empty queue leaves `count_o` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Received character strobe |
| wr_data_i | input | 8 | Received character |
| wr_pe_i | input | 1 | Parity error of received character |
| wr_fe_i | input | 1 | Framing error of received character |
| wr_bi_i | input | 1 | Break flag of received character |
| rd_i | input | 1 | CPU pop of the head entry |
| stat_rd_i | input | 1 | CPU status read |
| flush_i | input | 1 | Empty the queue |
| trig_sel_i | input | 2 | Fill threshold select |
| tick_i | input | 1 | 16x sample-rate enable |
| frame_ticks_i | input | 8 | Ticks per character |
| rd_data_o | output | 8 | Head entry data |
| head_pe_o | output | 1 | Head parity error |
| head_fe_o | output | 1 | Head framing error |
| head_bi_o | output | 1 | Head break flag |
| count_o | output | 5 | Number of stored entries |
| data_ready_o | output | 1 | At least one entry stored |
| avail_req_o | output | 1 | Fill threshold reached |
| timeout_req_o | output | 1 | Character timeout pending |
| overrun_o | output | 1 | Character lost to full queue |
| err_sum_o | output | 1 | Errored entry present (sticky) |

## Verification
The timeout is the hardest behaviour to reach. The bench holds `tick_i` high and uses a four-tick frame, so four character times become exactly sixteen clock edges. It then samples one edge before and one edge on the expected firing point. It does this three times: after a first write, after a write that restarts the timer, and after a pop that clears a fired request. Overrun needs the queue driven to exactly sixteen entries followed by one more strobe. The drain that follows confirms that the dropped character never appears.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              bi;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rxq_ent_t;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  logic      pop_i,
  input  logic      flush_i,
  input  rxq_ent_t  din_i,
  output rxq_ent_t  head_o,
  output logic [AW:0] count_o
);
  rxq_ent_t      mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end

  assign head_o  = (cnt_q != 0) ? mem_q[rp_q] : '0;
  assign count_o = cnt_q;
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int FT_W = 8,
  localparam int TW = FT_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [FT_W-1:0] frame_ticks_i,
  input  logic            stored_i,   // entries present after this edge
  input  logic            rx_i,
  input  logic            pop_i,
  output logic            fire_o
);
  logic [TW-1:0] tmr_q;
  logic          fire_q;
  logic [TW-1:0] limit;

  assign limit = {frame_ticks_i, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      fire_q <= 1'b0;
    end else if (!stored_i || pop_i) begin
      tmr_q  <= '0;
      fire_q <= 1'b0;
    end else if (fire_q) begin
      tmr_q  <= '0;
    end else if (rx_i) begin
      tmr_q  <= '0;
    end else if (tick_i) begin
      if (tmr_q + 1'b1 >= limit) begin
        tmr_q  <= '0;
        fire_q <= 1'b1;
      end else begin
        tmr_q  <= tmr_q + 1'b1;
      end
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/rxq_errs.sv
module rxq_errs #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic push_err_i,
  input  logic pop_i,
  input  logic pop_err_i,
  input  logic was_empty_i,
  input  logic drop_i,
  input  logic flush_i,
  input  logic stat_rd_i,
  output logic overrun_o,
  output logic err_sum_o,
  output logic head_mask_o
);
  logic [AW:0] ecnt_q, ecnt_d;
  logic        ovr_q, sum_q, ack_q;

  always_comb begin
    if (flush_i) ecnt_d = '0;
    else ecnt_d = ecnt_q + (AW+1)'(push_i & push_err_i) - (AW+1)'(pop_i & pop_err_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecnt_q <= '0;
      ovr_q  <= 1'b0;
      sum_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ecnt_q <= ecnt_d;
      if (drop_i)         ovr_q <= 1'b1;
      else if (stat_rd_i) ovr_q <= 1'b0;
      // sticky: only a status read with no errored entries left clears it
      if (ecnt_d != 0)    sum_q <= 1'b1;
      else if (stat_rd_i) sum_q <= 1'b0;
      // head error view is masked after a status read until the head changes
      if (flush_i || pop_i || (push_i && was_empty_i)) ack_q <= 1'b0;
      else if (stat_rd_i) ack_q <= 1'b1;
    end
  end

  assign overrun_o   = ovr_q;
  assign err_sum_o   = sum_q;
  assign head_mask_o = ack_q;
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FT_W  = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_pe_i,
  input  logic              wr_fe_i,
  input  logic              wr_bi_i,
  input  logic              rd_i,
  input  logic              stat_rd_i,
  input  logic              flush_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              tick_i,
  input  logic [FT_W-1:0]   frame_ticks_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              head_pe_o,
  output logic              head_fe_o,
  output logic              head_bi_o,
  output logic [AW:0]       count_o,
  output logic              data_ready_o,
  output logic              avail_req_o,
  output logic              timeout_req_o,
  output logic              overrun_o,
  output logic              err_sum_o
);
  rxq_ent_t    din, head;
  logic [AW:0] cnt;
  logic        empty, full, push, pop, drop, mask, stored_nx;

  assign din   = '{bi: wr_bi_i, fe: wr_fe_i, pe: wr_pe_i, data: wr_data_i};
  assign empty = (cnt == 0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign push  = wr_i && !full && !flush_i;
  assign drop  = wr_i && full && !flush_i;
  assign pop   = rd_i && !empty && !flush_i;
  assign stored_nx = !flush_i && ((cnt + (AW+1)'(push) - (AW+1)'(pop)) != 0);

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .flush_i,
    .din_i(din), .head_o(head), .count_o(cnt)
  );

  rxq_timer #(.FT_W(FT_W)) u_timer (
    .clk_i, .rst_ni, .tick_i, .frame_ticks_i, .stored_i(stored_nx),
    .rx_i(wr_i), .pop_i(pop), .fire_o(timeout_req_o)
  );

  rxq_errs #(.DEPTH(DEPTH)) u_errs (
    .clk_i, .rst_ni, .push_i(push), .push_err_i(wr_pe_i | wr_fe_i | wr_bi_i),
    .pop_i(pop), .pop_err_i(head.pe | head.fe | head.bi), .was_empty_i(empty),
    .drop_i(drop), .flush_i, .stat_rd_i, .overrun_o, .err_sum_o,
    .head_mask_o(mask)
  );

  assign rd_data_o    = head.data;
  assign head_pe_o    = head.pe & ~mask;
  assign head_fe_o    = head.fe & ~mask;
  assign head_bi_o    = head.bi & ~mask;
  assign count_o      = cnt;
  assign data_ready_o = !empty;
  assign avail_req_o  = cnt >= (AW+1)'(trig_level(trig_sel_i));
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic        rd_i,
  input logic        flush_i,
  input logic [AW:0] count_o,
  input logic        head_pe_o,
  input logic        head_fe_o,
  input logic        head_bi_o,
  input logic        timeout_req_o,
  input logic        overrun_o,
  input logic        err_sum_o
);
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= (AW+1)'(DEPTH));

  a_r6_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !flush_i && count_o == (AW+1)'(DEPTH)) |=> overrun_o);

  a_r6_no_grow_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == (AW+1)'(DEPTH) && !flush_i) |=> count_o <= (AW+1)'(DEPTH));

  a_r4_timeout_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_req_o |-> count_o != 0);

  a_r8_head_err_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_pe_o || head_fe_o || head_bi_o) |-> err_sum_o);

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_o == 0);

  a_r10_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == 0 && rd_i && !wr_i) |=> count_o == 0);
endmodule

bind uart_rxq rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .flush_i(flush_i),
  .count_o(count_o), .head_pe_o(head_pe_o), .head_fe_o(head_fe_o),
  .head_bi_o(head_bi_o), .timeout_req_o(timeout_req_o), .overrun_o(overrun_o),
  .err_sum_o(err_sum_o)
);

// File: tb/sim_uart_rxq.sv
`timescale 1ns/1ps
module sim_uart_rxq;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_i = 0, wr_pe_i = 0, wr_fe_i = 0, wr_bi_i = 0;
  logic [7:0] wr_data_i = 0;
  logic       rd_i = 0, stat_rd_i = 0, flush_i = 0, tick_i = 0;
  logic [1:0] trig_sel_i = 0;
  logic [7:0] frame_ticks_i = 8'd4;
  logic [7:0] rd_data_o;
  logic       head_pe_o, head_fe_o, head_bi_o;
  logic [4:0] count_o;
  logic       data_ready_o, avail_req_o, timeout_req_o, overrun_o, err_sum_o;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #2.5 clk_i = ~clk_i;

  uart_rxq u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk_i);
    wr_i = 1; wr_data_i = d; {wr_bi_i, wr_fe_i, wr_pe_i} = e;
    @(negedge clk_i);
    wr_i = 0; {wr_bi_i, wr_fe_i, wr_pe_i} = 3'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk_i); rd_i = 1;
    @(negedge clk_i); rd_i = 0;
  endtask

  task automatic pulse_stat();
    @(negedge clk_i); stat_rd_i = 1;
    @(negedge clk_i); stat_rd_i = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk_i); flush_i = 1;
    @(negedge clk_i); flush_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 count at reset", count_o, 0);
    chk("R1 ready at reset", data_ready_o, 0);
    chk("R10 data at reset", rd_data_o, 0);
    chk("R6 overrun at reset", overrun_o, 0);
    chk("R8 errsum at reset", err_sum_o, 0);
    chk("R4 timeout at reset", timeout_req_o, 0);
  endtask

  task automatic t_order_empty();
    push(8'hA1, 0); push(8'hB2, 0); push(8'hC3, 0);
    chk("R1 count 3", count_o, 3);
    chk("R1 ready", data_ready_o, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R1 order", rd_data_o, (i == 0) ? 'hA1 : (i == 1) ? 'hB2 : 'hC3);
      pulse_rd();
    end
    chk("R10 empty data zero", rd_data_o, 0);
    pulse_rd();
    chk("R10 empty pop count", count_o, 0);
    chk("R1 ready low", data_ready_o, 0);
  endtask

  task automatic t_trigger();
    for (int s = 0; s < 4; s++) begin
      int thr;
      thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      trig_sel_i = 2'(s);
      for (int k = 0; k < thr - 1; k++) push(8'(k), 0);
      chk("R2 below threshold", avail_req_o, 0);
      push(8'h55, 0);
      chk("R2 at threshold", avail_req_o, 1);
      pulse_rd();
      chk("R3 drop below", avail_req_o, 0);
      pulse_flush();
    end
    trig_sel_i = 0;
  endtask

  task automatic t_overrun();
    for (int k = 0; k < 16; k++) push(8'(8'h10 + k), 0);
    chk("R6 full count", count_o, 16);
    chk("R6 no overrun yet", overrun_o, 0);
    push(8'hEE, 0);
    chk("R6 overrun set", overrun_o, 1);
    chk("R6 count held", count_o, 16);
    for (int k = 0; k < 16; k++) begin
      chk("R6 drain order", rd_data_o, 8'h10 + k);
      pulse_rd();
    end
    chk("R6 dropped absent", count_o, 0);
    chk("R6 overrun sticky", overrun_o, 1);
    pulse_stat();
    chk("R6 overrun cleared", overrun_o, 0);
  endtask

  task automatic t_errors();
    push(8'h01, 3'b000); push(8'h02, 3'b001); push(8'h03, 3'b110);
    chk("R7 clean head", {head_bi_o, head_fe_o, head_pe_o}, 0);
    chk("R8 errsum set", err_sum_o, 1);
    pulse_stat();
    chk("R8 errsum kept", err_sum_o, 1);
    pulse_rd();
    chk("R7 pe at head", {head_bi_o, head_fe_o, head_pe_o}, 3'b001);
    pulse_stat();
    chk("R7 masked after stat", {head_bi_o, head_fe_o, head_pe_o}, 0);
    pulse_rd();
    chk("R7 fe bi at head", {head_bi_o, head_fe_o, head_pe_o}, 3'b110);
    pulse_rd();
    chk("R7 empty no flags", {head_bi_o, head_fe_o, head_pe_o}, 0);
    chk("R8 sticky after drain", err_sum_o, 1);
    pulse_stat();
    chk("R8 cleared", err_sum_o, 0);
  endtask

  task automatic t_timeout();
    frame_ticks_i = 8'd4;
    @(negedge clk_i); tick_i = 1;
    push(8'h71, 0);
    idle(15); chk("R4 not yet", timeout_req_o, 0);
    idle(1);  chk("R4 fired", timeout_req_o, 1);
    push(8'h72, 0);
    chk("R5 write keeps", timeout_req_o, 1);
    pulse_rd();
    chk("R5 pop clears", timeout_req_o, 0);
    idle(15); chk("R5 restart not yet", timeout_req_o, 0);
    idle(1);  chk("R5 refire", timeout_req_o, 1);
    pulse_rd();
    chk("R5 cleared on empty", timeout_req_o, 0);
    push(8'h73, 0);
    idle(9);
    push(8'h74, 0);
    idle(15); chk("R4 write restart", timeout_req_o, 0);
    idle(1);  chk("R4 fire after restart", timeout_req_o, 1);
    tick_i = 0;
    pulse_flush();
  endtask

  task automatic t_flush();
    push(8'h91, 3'b010); push(8'h92, 0);
    @(negedge clk_i); flush_i = 1; wr_i = 1; wr_data_i = 8'h93;
    @(negedge clk_i); flush_i = 0; wr_i = 0;
    chk("R9 flush count", count_o, 0);
    chk("R9 flush ready", data_ready_o, 0);
    chk("R9 flush data", rd_data_o, 0);
    pulse_stat();
    chk("R9 flush drops errors", err_sum_o, 0);
  endtask

  initial begin
    idle(3);
    rst_ni = 1;
    idle(1);
    t_reset();
    t_order_empty();
    t_trigger();
    t_overrun();
    t_errors();
    t_timeout();
    t_flush();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: got hang expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule